// File: doc/BRIEF.md
# Request-Acknowledge Liveness Monitor

This block watches a running program from the side and decides, once each time a function scope closes, whether every request seen inside that scope was later answered by an acknowledge. An observation unit elsewhere supplies a scope-active level and two per-cycle proposition bits, `req_i` and `ack_i`. The monitor steps a fixed four-state Moore machine on each clock while the scope is active. It turns the closing of the scope into a single terminal step. That step gives the verdict.

The closing of a scope is found internally as a 1-to-0 change of `scope_i` between two clock edges, so no signal is used as a clock. When a request is still open at that point, the scope is marked violated. When no request is open, it is marked satisfied. The verdict flags are registered and stay set while the scope is inactive. Each new scope entry clears them and starts over from the initial state. The current state is also driven out so that a trace can be followed step by step.

Top module: `rmon_req_ack_monitor`

## Requirements
- R1: While `rst_ni` is low, and on its release, `state_o` is 0 (IDLE), and `satisfied_o` and `violated_o` are both low.
- R2: On a clock edge where `scope_i` is 1 and was 0 at the previous edge (entry), `state_o` becomes 0 and both flags clear. `req_i` and `ack_i` are ignored on that edge.
- R3: In state 0 with the scope active and no entry or exit, `req_i`=1 with `ack_i`=0 moves to state 1 (PENDING). Any other combination keeps state 0; this includes `req_i`=1 with `ack_i`=1.
- R4: In state 1 with the scope active and no entry or exit, `ack_i`=1 returns to state 0 whatever `req_i` is. `ack_i`=0 keeps state 1.
- R5: On a clock edge where `scope_i` is 0 and was 1 at the previous edge (exit), state 0 moves to state 2 (PASSED) and `satisfied_o` rises on that edge. `req_i` and `ack_i` are ignored on the exit edge.
- R6: On an exit edge, state 1 moves to state 3 (FAILED) and `violated_o` rises on that edge, even if `ack_i` is 1 in that cycle.
- R7: `satisfied_o` and `violated_o` are never high together. Once set, a flag stays set until the next entry edge.
- R8: The trace (req,ack) = 10, 01, 10 followed by an exit walks the states 1, 0, 1 and ends in state 3 with `violated_o` high.
- R9: While `scope_i` is 0 and no exit is taking place, the state and both flags hold whatever `req_i` and `ack_i` do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scope_i | input | 1 | Monitored function scope is active |
| req_i | input | 1 | Request proposition for this cycle |
| ack_i | input | 1 | Acknowledge proposition for this cycle |
| state_o | output | 2 | Monitor state: 0 IDLE, 1 PENDING, 2 PASSED, 3 FAILED |
| satisfied_o | output | 1 | Sticky verdict: the scope closed with no open request |
| violated_o | output | 1 | Sticky verdict: the scope closed with a request open |

## Verification
A wrong internal state shows on `state_o` at the very next sampling point after the edge that caused it. The more serious case is an open request that is lost. It stays silent in the state flags until the scope closes. At that moment it turns a violation into a satisfied verdict. For this reason, exits are driven from every reachable state, and exits are driven in cycles where `req_i` or `ack_i` are high, so that a verdict taken from the wrong cycle also appears one edge after the scope drops. Idle stretches with the propositions toggling show whether the verdict flags hold.

// File: rtl/rmon_pkg.sv
package rmon_pkg;
  localparam int unsigned STATE_W = 2;

  typedef enum logic [STATE_W-1:0] {
    ST_IDLE    = 2'd0,
    ST_PENDING = 2'd1,
    ST_PASSED  = 2'd2,
    ST_FAILED  = 2'd3
  } mon_state_e;
endpackage

// File: rtl/rmon_scope_edge.sv
module rmon_scope_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scope_i,
  output logic entry_o,
  output logic exit_o
);
  logic scope_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) scope_q <= 1'b0;
    else         scope_q <= scope_i;
  end

  assign entry_o = scope_i & ~scope_q;
  assign exit_o  = ~scope_i & scope_q;
endmodule

// File: rtl/rmon_next_state.sv
module rmon_next_state
  import rmon_pkg::*;
(
  input  mon_state_e state_i,
  input  logic       scope_i,
  input  logic       entry_i,
  input  logic       exit_i,
  input  logic       req_i,
  input  logic       ack_i,
  output mon_state_e state_o
);
  always_comb begin
    state_o = state_i;
    if (entry_i) begin
      state_o = ST_IDLE;
    end else if (exit_i) begin
      // terminal step: the open-request status decides the verdict
      unique case (state_i)
        ST_IDLE:    state_o = ST_PASSED;
        ST_PENDING: state_o = ST_FAILED;
        default:    state_o = state_i;
      endcase
    end else if (scope_i) begin
      unique case (state_i)
        ST_IDLE:    if (req_i && !ack_i) state_o = ST_PENDING;
        ST_PENDING: if (ack_i)           state_o = ST_IDLE;
        default:    state_o = state_i;
      endcase
    end
  end
endmodule

// File: rtl/rmon_verdict.sv
module rmon_verdict
  import rmon_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       entry_i,
  input  mon_state_e state_d_i,
  output mon_state_e state_q_o,
  output logic       sat_o,
  output logic       vio_o
);
  mon_state_e state_q;
  logic       sat_q, vio_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      sat_q   <= 1'b0;
      vio_q   <= 1'b0;
    end else begin
      state_q <= state_d_i;
      if (entry_i) begin
        sat_q <= 1'b0;
        vio_q <= 1'b0;
      end else begin
        sat_q <= sat_q | (state_d_i == ST_PASSED);
        vio_q <= vio_q | (state_d_i == ST_FAILED);
      end
    end
  end

  assign state_q_o = state_q;
  assign sat_o     = sat_q;
  assign vio_o     = vio_q;
endmodule

// File: rtl/rmon_req_ack_monitor.sv
module rmon_req_ack_monitor
  import rmon_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               scope_i,
  input  logic               req_i,
  input  logic               ack_i,
  output logic [STATE_W-1:0] state_o,
  output logic               satisfied_o,
  output logic               violated_o
);
  logic       entry_w, exit_w;
  mon_state_e state_d, state_q;
  logic       sat_w, vio_w;

  rmon_scope_edge u_edge (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .scope_i (scope_i),
    .entry_o (entry_w),
    .exit_o  (exit_w)
  );

  rmon_next_state u_next (
    .state_i (state_q),
    .scope_i (scope_i),
    .entry_i (entry_w),
    .exit_i  (exit_w),
    .req_i   (req_i),
    .ack_i   (ack_i),
    .state_o (state_d)
  );

  rmon_verdict u_verdict (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .entry_i   (entry_w),
    .state_d_i (state_d),
    .state_q_o (state_q),
    .sat_o     (sat_w),
    .vio_o     (vio_w)
  );

  assign state_o     = state_q;
  assign satisfied_o = sat_w;
  assign violated_o  = vio_w;
endmodule

// File: rtl/rmon_req_ack_monitor_chk.sv
module rmon_req_ack_monitor_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       scope_i,
  input logic       req_i,
  input logic       ack_i,
  input logic       entry_i,
  input logic       exit_i,
  input logic [1:0] state_i,
  input logic       sat_i,
  input logic       vio_i
);
  a_r1_reset_idle: assert property (@(posedge clk_i)
    !rst_ni |-> (state_i == 2'd0 && !sat_i && !vio_i));

  a_r2_entry_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    entry_i |=> (state_i == 2'd0 && !sat_i && !vio_i));

  a_r3_req_opens: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scope_i && !entry_i && state_i == 2'd0 && req_i && !ack_i) |=> state_i == 2'd1);

  a_r4_ack_closes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scope_i && !entry_i && state_i == 2'd1 && ack_i) |=> state_i == 2'd0);

  a_r5_exit_idle_passes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exit_i && state_i == 2'd0) |=> (state_i == 2'd2 && sat_i));

  a_r6_exit_open_fails: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exit_i && state_i == 2'd1) |=> (state_i == 2'd3 && vio_i));

  a_r7_flags_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sat_i && vio_i));

  a_r7_sat_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sat_i && !entry_i) |=> sat_i);

  a_r7_vio_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vio_i && !entry_i) |=> vio_i);

  a_r9_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!scope_i && !exit_i) |=> ($stable(state_i) && $stable(sat_i) && $stable(vio_i)));
endmodule

bind rmon_req_ack_monitor rmon_req_ack_monitor_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .scope_i (scope_i),
  .req_i   (req_i),
  .ack_i   (ack_i),
  .entry_i (entry_w),
  .exit_i  (exit_w),
  .state_i (state_q),
  .sat_i   (sat_w),
  .vio_i   (vio_w)
);

// File: tb/rmon_req_ack_monitor_test.sv
module rmon_req_ack_monitor_test;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       scope = 1'b0, req = 1'b0, ack = 1'b0;
  logic [1:0] state;
  logic       sat, vio;

  int n_tests = 0;
  int n_fail  = 0;

  typedef struct {
    logic [1:0] st;
    logic       s;
    logic       v;
    string      tag;
  } exp_t;

  exp_t q[$];

  // reference model
  logic [1:0] m_st = 2'd0;
  logic       m_sat = 1'b0, m_vio = 1'b0, m_scope = 1'b0;

  always #2 clk = ~clk;

  rmon_req_ack_monitor uut (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .scope_i     (scope),
    .req_i       (req),
    .ack_i       (ack),
    .state_o     (state),
    .satisfied_o (sat),
    .violated_o  (vio)
  );

  task automatic report_done();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  task automatic compare(input exp_t e);
    n_tests++;
    if (state !== e.st || sat !== e.s || vio !== e.v) begin
      n_fail++;
      $display("FAIL %s: state/sat/vio actual %0d/%0b/%0b expected %0d/%0b/%0b",
               e.tag, state, sat, vio, e.st, e.s, e.v);
    end
  endtask

  task automatic step(input logic sc, input logic rq, input logic ak, input string tag);
    exp_t e;
    @(negedge clk);
    scope = sc; req = rq; ack = ak;
    if (sc && !m_scope) begin
      m_st = 2'd0; m_sat = 1'b0; m_vio = 1'b0;
    end else if (!sc && m_scope) begin
      if (m_st == 2'd0) begin m_st = 2'd2; m_sat = 1'b1; end
      else if (m_st == 2'd1) begin m_st = 2'd3; m_vio = 1'b1; end
    end else if (sc) begin
      if (m_st == 2'd0 && rq && !ak) m_st = 2'd1;
      else if (m_st == 2'd1 && ak)   m_st = 2'd0;
    end
    m_scope = sc;
    e.st = m_st; e.s = m_sat; e.v = m_vio; e.tag = tag;
    q.push_back(e);
  endtask

  // monitor: one expected item per clock edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) compare(q.pop_front());
    end
  end

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual timeout expected completion");
    report_done();
  end

  initial begin
    exp_t r;
    #5;
    r.st = 2'd0; r.s = 1'b0; r.v = 1'b0; r.tag = "R1 in reset";
    compare(r);
    @(negedge clk); rst_ni = 1'b1;
    @(posedge clk); #1;
    r.tag = "R1 after release";
    compare(r);

    // out of scope, propositions toggling
    step(0, 1, 0, "R9 idle req");
    step(0, 0, 1, "R9 idle ack");
    // entry ignores req in the same cycle
    step(1, 1, 0, "R2 entry");
    // fixed trace
    step(1, 1, 0, "R8 req");
    step(1, 0, 1, "R8 ack");
    step(1, 1, 0, "R8 req again");
    step(0, 0, 0, "R8 exit pending");
    step(0, 1, 1, "R7 hold vio");
    step(0, 1, 0, "R9 hold vio");
    // re-entry clears flags
    step(1, 0, 0, "R2 re-entry");
    step(1, 1, 1, "R3 req with ack");
    step(1, 0, 0, "R3 quiet");
    step(1, 0, 1, "R3 lone ack");
    step(1, 1, 0, "R3 open");
    step(1, 1, 0, "R4 req while open");
    step(1, 0, 0, "R4 wait");
    step(1, 1, 1, "R4 req+ack closes");
    step(0, 1, 0, "R5 exit idle with req");
    step(0, 1, 0, "R7 hold sat");
    step(0, 0, 1, "R9 hold sat");
    // exit with ack in the exit cycle still fails
    step(1, 0, 0, "R2 entry from sat");
    step(1, 1, 0, "R3 open again");
    step(0, 0, 1, "R6 exit ack ignored");
    step(0, 0, 0, "R7 vio stays");
    // immediate exit after entry
    step(1, 1, 0, "R2 entry from vio");
    step(0, 1, 0, "R5 exit right after entry");
    step(0, 0, 0, "R7 sat stays");
    step(0, 0, 0, "R9 drain");
    @(negedge clk);
    @(negedge clk);
    report_done();
  end
endmodule